// File: doc/BRIEF.md
# Column-Sum Unsigned Multiplier

This block multiplies two unsigned N-bit operands and returns the full 2N-bit product in pure combinational logic. It does not add shifted rows. It works one output column at a time. Column k collects every bit product a[i]&b[j] with i+j equal to k and adds the carry handed on by column k-1. The lowest bit of that sum is product bit k, and every higher bit of the sum moves on as the carry into column k+1.

The bit products of all 2N-1 columns are formed side by side. Only the carry runs serially from column to column, and it may be several bits wide. Once the last column is done, the carry that remains supplies the top product bit. The carry path is sized at ceil(log2(N*(N+1))) bits so that no column sum can overflow. The width parameter N is meant to be 3, 4, 8 or 16. The unit is used wherever a single-cycle unsigned product is needed, for example as the core of a squaring or cubing datapath.

Top module: `colmul`

## Requirements
- R1: For every operand pair, `p` equals the unsigned product `a*b`, zero-extended to 2N bits.
- R2: Column alignment: with `a = 2^i` and `b = 2^j`, the product has exactly one bit set, at position i+j.
- R3: No product bit is lost to the carry. After the last column the remaining carry is 0 or 1, and all-ones operands give (2^N-1)^2 (for N=4 this is 0xE1).
- R4: If either operand is zero, the product is zero.
- R5: If one operand equals 1, the product equals the other operand zero-extended.
- R6: The block has no clock and no state. `p` follows a change of `a` or `b` within the same time step, with no clock edge between them.
- R7: R1 to R5 hold for each supported width N = 3, 4, 8 and 16.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a | input | N | Multiplicand, unsigned |
| b | input | N | Multiplier, unsigned |
| p | output | 2N | Product, unsigned |

## Verification
The hardest case to reach is a carry several bits wide that crosses the middle columns, where up to N bit products meet an incoming carry. This only happens when many bit pairs in the same column are 1 together. The stimulus gets there in three ways. It covers N=4 exhaustively. It drives all-ones and other dense operands at every width. It applies a large set of random pairs at N=8 and N=16, which land on heavily loaded columns often. Single-bit operand pairs isolate the placement of each column, so that an off-by-one in the column index cannot be hidden by carries.

// File: rtl/colmul.sv
module colmul #(
  parameter int N = 8
) (
  input  logic [N-1:0]   a,
  input  logic [N-1:0]   b,
  output logic [2*N-1:0] p
);
  localparam int COLS = 2*N - 1;
  localparam int SW   = $clog2(N*(N+1));

  logic [N-1:0]  pp     [COLS];
  logic [SW-1:0] colsum [COLS];
  logic [SW-1:0] cy     [COLS+1];
  logic [SW-1:0] tail_carry;

  assign cy[0] = '0;

  for (genvar k = 0; k < COLS; k++) begin : g_col
    for (genvar i = 0; i < N; i++) begin : g_bit
      if (k >= i && k - i < N) begin : g_on
        assign pp[k][i] = a[i] & b[k-i];
      end else begin : g_off
        assign pp[k][i] = 1'b0;
      end
    end
    assign colsum[k] = SW'($countones(pp[k])) + cy[k];
    assign p[k]      = colsum[k][0];
    assign cy[k+1]   = {1'b0, colsum[k][SW-1:1]};
  end

  assign tail_carry = cy[COLS];
  assign p[2*N-1]   = tail_carry[0];
endmodule

module colmul_chk #(
  parameter int N  = 8,
  parameter int SW = 4
) (
  input logic [N-1:0]   a,
  input logic [N-1:0]   b,
  input logic [2*N-1:0] p,
  input logic [SW-1:0]  tail
);
  logic [2*N-1:0] ref_p;
  assign ref_p = {{N{1'b0}}, a} * {{N{1'b0}}, b};

  always_comb begin
    a_r1_product: assert (p == ref_p)
      else $error("R1 product mismatch");
    a_r3_no_overflow: assert (tail[SW-1:1] == '0)
      else $error("R3 carry beyond top column");
    a_r4_zero: assert (!((a == '0) || (b == '0)) || (p == '0))
      else $error("R4 zero operand gave nonzero product");
    a_r5_identity: assert ((b != N'(1)) || (p == {{N{1'b0}}, a}))
      else $error("R5 identity failed");
    a_r2_single_bit: assert (!($onehot(a) && $onehot(b)) || $onehot(p))
      else $error("R2 single-bit product not one-hot");
  end
endmodule

bind colmul colmul_chk #(.N(N), .SW(SW)) u_chk (
  .a(a), .b(b), .p(p), .tail(tail_carry)
);

// File: tb/sim_colmul.sv
`timescale 1ns/1ps
module sim_colmul;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic [2:0]  a3 = '0, b3 = '0;
  logic [3:0]  a4 = '0, b4 = '0;
  logic [7:0]  a8 = '0, b8 = '0;
  logic [15:0] a16 = '0, b16 = '0;
  logic [5:0]  p3;
  logic [7:0]  p4;
  logic [15:0] p8;
  logic [31:0] p16;

  colmul #(.N(4))  u0 (.a(a4),  .b(b4),  .p(p4));
  colmul #(.N(8))  u1 (.a(a8),  .b(b8),  .p(p8));
  colmul #(.N(16)) u2 (.a(a16), .b(b16), .p(p16));
  colmul #(.N(3))  u3 (.a(a3),  .b(b3),  .p(p3));

  int n_run = 0;
  int n_fail = 0;

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    n_run++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s got=%0h exp=%0h", req, got, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic t_reset();
    step(); #1;
    chk("R4 reset-zero N3", 32'(p3), 0);
    chk("R4 reset-zero N4", 32'(p4), 0);
    chk("R4 reset-zero N8", 32'(p8), 0);
    chk("R4 reset-zero N16", p16, 0);
  endtask

  task automatic t_exhaustive4();
    for (int x = 0; x < 16; x++) begin
      for (int y = 0; y < 16; y++) begin
        step(); a4 = 4'(x); b4 = 4'(y); #1;
        chk("R1 N4 exhaustive", 32'(p4), 32'(x*y));
      end
    end
    for (int x = 0; x < 8; x++) begin
      for (int y = 0; y < 8; y++) begin
        step(); a3 = 3'(x); b3 = 3'(y); #1;
        chk("R7 N3 exhaustive", 32'(p3), 32'(x*y));
      end
    end
  endtask

  task automatic t_all_ones();
    step(); a3 = '1; b3 = '1; a4 = '1; b4 = '1; a8 = '1; b8 = '1; a16 = '1; b16 = '1; #1;
    chk("R3 all-ones N3", 32'(p3), 32'd49);
    chk("R3 all-ones N4", 32'(p4), 32'h0E1);
    chk("R3 all-ones N8", 32'(p8), 32'd65025);
    chk("R3 all-ones N16", p16, 32'hFFFE0001);
  endtask

  task automatic t_onehot();
    for (int i = 0; i < 16; i++) begin
      for (int j = 0; j < 16; j++) begin
        step(); a16 = 16'(1) << i; b16 = 16'(1) << j;
        a8 = 8'(1) << (i % 8); b8 = 8'(1) << (j % 8); #1;
        chk("R2 onehot N16", p16, 32'(1) << (i + j));
        chk("R2 onehot N8", 32'(p8), 32'(1) << ((i % 8) + (j % 8)));
      end
    end
  endtask

  task automatic t_identity();
    for (int k = 0; k < 40; k++) begin
      logic [15:0] r;
      r = 16'($urandom);
      step(); a16 = r; b16 = 16'd1; a8 = r[7:0]; b8 = 8'd1; #1;
      chk("R5 identity b=1 N16", p16, {16'd0, r});
      chk("R5 identity b=1 N8", 32'(p8), 32'(r[7:0]));
      step(); a16 = 16'd1; b16 = r; #1;
      chk("R5 identity a=1 N16", p16, {16'd0, r});
    end
  endtask

  task automatic t_zero();
    for (int k = 0; k < 20; k++) begin
      step(); a16 = 16'($urandom); b16 = '0; a8 = '0; b8 = 8'($urandom); #1;
      chk("R4 zero N16", p16, 0);
      chk("R4 zero N8", 32'(p8), 0);
    end
  endtask

  task automatic t_random();
    for (int k = 0; k < 2000; k++) begin
      logic [15:0] x, y;
      x = 16'($urandom); y = 16'($urandom);
      if (k % 7 == 0) x = x | 16'hF0F0;
      step(); a16 = x; b16 = y; a8 = x[15:8]; b8 = y[7:0]; #1;
      chk("R1 random N16", p16, {16'd0, x} * {16'd0, y});
      chk("R1 random N8", 32'(p8), 32'({8'd0, x[15:8]} * {8'd0, y[7:0]}));
    end
  endtask

  task automatic t_comb();
    step();
    a16 = 16'd300; b16 = 16'd7; #0.5;
    chk("R6 comb first", p16, 32'd2100);
    a16 = 16'd1000; #0.5;
    chk("R6 comb second", p16, 32'd7000);
    b16 = 16'hFFFF; #0.5;
    chk("R6 comb third", p16, 32'd1000 * 32'hFFFF);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    t_reset();
    t_exhaustive4();
    t_all_ones();
    t_onehot();
    t_identity();
    t_zero();
    t_random();
    t_comb();
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_run++;
    n_fail++;
    $display("FAIL watchdog expired got=running exp=done");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule